// File: doc/BRIEF.md
# Packed Decimal Pack/Unpack Engine

This block converts a decimal field between two byte formats. In the zoned format each byte holds one digit in its low nibble and a zone in its high nibble. In the packed format each byte holds two digits. In both formats the sign sits in the least significant byte. One start pulse sets the direction, the sign convention and the two field lengths. The engine then fetches source bytes one at a time over a request/acknowledge port and returns destination bytes the same way. It works from the least significant byte upward. At the end it reports the sign it decoded and whether the field was well formed.

Byte index 0 on both ports is the least significant byte of the field. A length code of `n` means `n+1` bytes, so a field is 1 to 16 bytes long. When the destination needs more digits than the source holds, the extra positions are filled with zero digits. When the destination holds fewer digits than the source, the upper source digits are dropped and are never fetched. Two sign conventions are available at run time. In the standard convention the engine writes 1010 for plus and 1011 for minus, and fills zones with 0011. In the alternate convention it writes 1100 for plus and 1101 for minus, and fills zones with 1111. On input, any of the six codes 1010 to 1111 is accepted as a sign, whichever convention is selected.

The controller moves through these states:
- `S_IDLE` goes to `S_PICK_LO` on start.
- `S_PICK_LO` goes to `S_FETCH_LO` if the byte it needs is not held yet. Otherwise it goes to `S_PICK_HI`.
- `S_FETCH_LO` returns to `S_PICK_LO` on a read acknowledge.
- `S_PICK_HI` goes to `S_FETCH_HI` if the byte it needs is not held yet. Otherwise it goes to `S_WRITE`.
- `S_FETCH_HI` returns to `S_PICK_HI` on a read acknowledge.
- `S_WRITE` waits for a write acknowledge. It then goes to `S_DONE` after the last destination byte, or to `S_PICK_LO` for the next one.
- `S_DONE` returns to `S_IDLE` after one cycle.

Top module: `dpk_engine`

## Requirements
- R1: Pack (`unpack_i`=0) builds destination byte 0 from the source byte-0 digit in the high nibble and the normalised sign in the low nibble. Destination byte j>0 holds source digit 2j in the high nibble and digit 2j-1 in the low nibble. Source digit k is the low nibble of source byte k, and the sign is the high nibble of source byte 0.
- R2: Unpack (`unpack_i`=1) reads packed digits as follows: digit 0 is the high nibble of byte 0, an odd digit k is the low nibble of byte (k+1)/2, and an even digit k>0 is the high nibble of byte k/2. The sign is the low nibble of byte 0. Destination byte 0 is {sign code, digit 0}. Destination byte j>0 is {zone, digit j}, where the zone is 0011 in the standard convention and 1111 in the alternate one.
- R3: A sign nibble of 1011 or 1101 decodes as minus. A sign nibble of 1010, 1100, 1110 or 1111 decodes as plus. At done, `sign_ok_o`=1 and `sign_neg_o` shows the polarity.
- R4: The sign code written is 1010 for plus and 1011 for minus when `alt_mode_i`=0, and 1100 for plus and 1101 for minus when `alt_mode_i`=1. A sign nibble from 0000 to 1001 gives `sign_ok_o`=0, `sign_neg_o`=0 and `data_err_o`=1, and the plus code is written.
- R5: Length codes give `code+1` bytes. Digit positions beyond the source are written as 0000. Source digits beyond what the destination can hold are dropped.
- R6: A fetched digit nibble above 1001 sets `data_err_o`. The conversion still completes, and that nibble is copied unchanged into the destination.
- R7: In pack, the high nibbles of source bytes other than byte 0 have no effect on the result or the flags.
- R8: Source bytes are read in ascending order starting at index 0, each at most once. For pack, the number of reads is min(Ns, 2·Nd−1), and for unpack it is min(Ns, ⌊Nd/2⌋+1), where Ns and Nd are the source and destination byte counts. Destination bytes are written exactly once each, in order from 0 to Nd−1. A read request and a write request are never raised together.
- R9: A raised request keeps its index, and for writes its data, stable until the matching acknowledge is seen.
- R10: The first read request appears two cycles after the start cycle. `done_o` is a one-cycle pulse in the cycle after the final write acknowledge, and `busy_o` falls with it.
- R11: A start pulse while `busy_o` is high is ignored. The direction, convention and lengths are sampled only at an accepted start.
- R12: After reset all flags are 0. An accepted start clears them. Once `done_o` has pulsed, they hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a conversion (accepted only when idle) |
| unpack_i | input | 1 | 0 = zoned to packed, 1 = packed to zoned |
| alt_mode_i | input | 1 | Sign/zone convention select |
| src_len_i | input | LEN_W | Source length code (bytes − 1) |
| dst_len_i | input | LEN_W | Destination length code (bytes − 1) |
| rd_req_o | output | 1 | Source byte read request |
| rd_idx_o | output | LEN_W | Source byte index, 0 = least significant |
| rd_ack_i | input | 1 | Read acknowledge; `rd_data_i` is valid with it |
| rd_data_i | input | 8 | Source byte |
| wr_req_o | output | 1 | Destination byte write request |
| wr_idx_o | output | LEN_W | Destination byte index, 0 = least significant |
| wr_data_o | output | 8 | Destination byte |
| wr_ack_i | input | 1 | Write acknowledge |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sign_ok_o | output | 1 | The sign nibble was a valid sign code |
| sign_neg_o | output | 1 | The decoded sign is minus |
| data_err_o | output | 1 | Invalid digit or sign seen |

## Verification
After the start edge, the first read request is due two falling edges later. Each acknowledge is seen at the next rising edge. `done_o` is due exactly one falling edge after the edge at which the final write acknowledge was raised. All three flags are valid with that pulse. The bench drives and samples only on falling edges and numbers them from the start edge. It records the edge at which each acknowledge was raised and compares the edges of the first request and of `done_o` against these counts. Stalls on both ports are random, so the request-hold rules are tested across varied waits.

// File: rtl/dpk_pkg.sv
package dpk_pkg;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_PICK_LO  = 3'd1,
        S_FETCH_LO = 3'd2,
        S_PICK_HI  = 3'd3,
        S_FETCH_HI = 3'd4,
        S_WRITE    = 3'd5,
        S_DONE     = 3'd6
    } dpk_state_e;

    // What a destination nibble is made of
    typedef enum logic [1:0] {
        NIB_DIGIT = 2'd0,
        NIB_SIGN  = 2'd1,
        NIB_ZONE  = 2'd2
    } dpk_nib_e;

    localparam logic [3:0] BCD_MAX = 4'd9;

endpackage

// File: rtl/dpk_nibble_map.sv
// Locates the source nibble that feeds one half of a destination byte.
module dpk_nibble_map #(
    parameter int LEN_W = 4
) (
    input  logic                  unpack_i,
    input  logic [LEN_W-1:0]      out_idx_i,
    input  logic                  hi_half_i,
    output dpk_pkg::dpk_nib_e     kind_o,
    output logic [LEN_W:0]        src_byte_o,
    output logic                  src_hi_o
);
    import dpk_pkg::*;

    localparam logic [LEN_W:0] ONE = {{LEN_W{1'b0}}, 1'b1};

    logic [LEN_W:0] j_ext;
    logic [LEN_W:0] j_dbl;
    logic [LEN_W:0] j_inc;
    logic           j_zero;

    assign j_ext  = {1'b0, out_idx_i};
    assign j_dbl  = {out_idx_i, 1'b0};
    assign j_inc  = j_ext + ONE;
    assign j_zero = (out_idx_i == '0);

    always_comb begin
        kind_o     = NIB_DIGIT;
        src_byte_o = '0;
        src_hi_o   = 1'b0;
        if (!unpack_i) begin
            // zoned source: digit k lives in low nibble of byte k
            if (!hi_half_i) begin
                if (j_zero) begin
                    kind_o   = NIB_SIGN;
                    src_hi_o = 1'b1;
                end else begin
                    src_byte_o = j_dbl - ONE;
                end
            end else begin
                src_byte_o = j_dbl;
            end
        end else begin
            // packed source: two digits per byte, sign in byte 0 low
            if (!hi_half_i) begin
                if (j_zero) begin
                    src_hi_o = 1'b1;
                end else if (out_idx_i[0]) begin
                    src_byte_o = j_inc >> 1;
                end else begin
                    src_byte_o = j_ext >> 1;
                    src_hi_o   = 1'b1;
                end
            end else begin
                if (j_zero) begin
                    kind_o = NIB_SIGN;
                end else begin
                    kind_o = NIB_ZONE;
                end
            end
        end
    end

endmodule

// File: rtl/dpk_sign_norm.sv
// Decodes any sign nibble and produces the code of the selected convention.
module dpk_sign_norm #(
    parameter logic [3:0] PLUS_STD  = 4'hA,
    parameter logic [3:0] MINUS_STD = 4'hB,
    parameter logic [3:0] PLUS_ALT  = 4'hC,
    parameter logic [3:0] MINUS_ALT = 4'hD
) (
    input  logic [3:0] nib_i,
    input  logic       alt_i,
    output logic       ok_o,
    output logic       neg_o,
    output logic [3:0] code_o
);
    always_comb begin
        ok_o  = 1'b0;
        neg_o = 1'b0;
        unique case (nib_i)
            4'hB, 4'hD: begin
                ok_o  = 1'b1;
                neg_o = 1'b1;
            end
            4'hA, 4'hC, 4'hE, 4'hF: ok_o = 1'b1;
            default: ;
        endcase
        if (alt_i) begin
            code_o = neg_o ? MINUS_ALT : PLUS_ALT;
        end else begin
            code_o = neg_o ? MINUS_STD : PLUS_STD;
        end
    end

endmodule

// File: rtl/dpk_src_hold.sv
// Single-entry holding register for the most recently fetched source byte.
module dpk_src_hold #(
    parameter int LEN_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_i,
    input  logic           load_i,
    input  logic [LEN_W:0] load_idx_i,
    input  logic [7:0]     load_byte_i,
    input  logic [LEN_W:0] look_idx_i,
    output logic           hit_o,
    output logic [7:0]     byte_o
);
    logic           vld_q;
    logic [LEN_W:0] idx_q;
    logic [7:0]     byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            idx_q  <= '0;
            byte_q <= '0;
        end else if (clr_i) begin
            vld_q <= 1'b0;
        end else if (load_i) begin
            vld_q  <= 1'b1;
            idx_q  <= load_idx_i;
            byte_q <= load_byte_i;
        end
    end

    assign hit_o  = vld_q && (idx_q == look_idx_i);
    assign byte_o = byte_q;

endmodule

// File: rtl/dpk_engine.sv
// Byte-serial zoned <-> packed decimal converter.
module dpk_engine #(
    parameter int         LEN_W     = 4,
    parameter logic [3:0] ZONE_STD  = 4'h3,
    parameter logic [3:0] ZONE_ALT  = 4'hF,
    parameter logic [3:0] PLUS_STD  = 4'hA,
    parameter logic [3:0] MINUS_STD = 4'hB,
    parameter logic [3:0] PLUS_ALT  = 4'hC,
    parameter logic [3:0] MINUS_ALT = 4'hD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             unpack_i,
    input  logic             alt_mode_i,
    input  logic [LEN_W-1:0] src_len_i,
    input  logic [LEN_W-1:0] dst_len_i,
    output logic             rd_req_o,
    output logic [LEN_W-1:0] rd_idx_o,
    input  logic             rd_ack_i,
    input  logic [7:0]       rd_data_i,
    output logic             wr_req_o,
    output logic [LEN_W-1:0] wr_idx_o,
    output logic [7:0]       wr_data_o,
    input  logic             wr_ack_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             sign_ok_o,
    output logic             sign_neg_o,
    output logic             data_err_o
);
    import dpk_pkg::*;

    localparam int IX_W = LEN_W + 1;

    dpk_state_e       state_q, state_d;
    logic             unpack_q, alt_q;
    logic [LEN_W-1:0] slen_q, dlen_q, j_q;
    logic [3:0]       lo_q, hi_q;
    logic             err_q, sok_q, sneg_q;

    logic             accept;
    logic             hi_half;
    logic             fetching;
    dpk_nib_e         map_kind;
    logic [IX_W-1:0]  map_byte;
    logic             map_hi;
    logic             in_range;
    logic             hold_hit;
    logic [7:0]       hold_byte;
    logic [3:0]       nib_sel;
    logic             sg_ok, sg_neg;
    logic [3:0]       sg_code;
    logic             need_fetch;
    logic [3:0]       pick_val;
    logic             digit_bad;
    logic             picking;
    logic             last_out;

    assign accept   = (state_q == S_IDLE) && start_i;
    assign hi_half  = (state_q == S_PICK_HI) || (state_q == S_FETCH_HI);
    assign fetching = (state_q == S_FETCH_LO) || (state_q == S_FETCH_HI);
    assign last_out = (j_q == dlen_q);

    dpk_nibble_map #(.LEN_W(LEN_W)) u_map (
        .unpack_i  (unpack_q),
        .out_idx_i (j_q),
        .hi_half_i (hi_half),
        .kind_o    (map_kind),
        .src_byte_o(map_byte),
        .src_hi_o  (map_hi)
    );

    dpk_src_hold #(.LEN_W(LEN_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (accept),
        .load_i     (fetching && rd_ack_i),
        .load_idx_i (map_byte),
        .load_byte_i(rd_data_i),
        .look_idx_i (map_byte),
        .hit_o      (hold_hit),
        .byte_o     (hold_byte)
    );

    assign nib_sel  = map_hi ? hold_byte[7:4] : hold_byte[3:0];
    assign in_range = (map_byte <= {1'b0, slen_q});

    dpk_sign_norm #(
        .PLUS_STD (PLUS_STD),
        .MINUS_STD(MINUS_STD),
        .PLUS_ALT (PLUS_ALT),
        .MINUS_ALT(MINUS_ALT)
    ) u_sign (
        .nib_i (nib_sel),
        .alt_i (alt_q),
        .ok_o  (sg_ok),
        .neg_o (sg_neg),
        .code_o(sg_code)
    );

    // Resolve the nibble for the current half
    always_comb begin
        need_fetch = 1'b0;
        pick_val   = 4'd0;
        digit_bad  = 1'b0;
        unique case (map_kind)
            NIB_ZONE: pick_val = alt_q ? ZONE_ALT : ZONE_STD;
            NIB_SIGN: begin
                need_fetch = !hold_hit;
                pick_val   = sg_code;
            end
            default: begin
                if (in_range) begin
                    need_fetch = !hold_hit;
                    pick_val   = nib_sel;
                    digit_bad  = (nib_sel > BCD_MAX);
                end
            end
        endcase
    end

    assign picking = ((state_q == S_PICK_LO) || (state_q == S_PICK_HI)) && !need_fetch;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start_i) state_d = S_PICK_LO;
            S_PICK_LO:  state_d = need_fetch ? S_FETCH_LO : S_PICK_HI;
            S_FETCH_LO: if (rd_ack_i) state_d = S_PICK_LO;
            S_PICK_HI:  state_d = need_fetch ? S_FETCH_HI : S_WRITE;
            S_FETCH_HI: if (rd_ack_i) state_d = S_PICK_HI;
            S_WRITE:    if (wr_ack_i) state_d = last_out ? S_DONE : S_PICK_LO;
            S_DONE:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rd_req_o   = fetching;
        rd_idx_o   = map_byte[LEN_W-1:0];
        wr_req_o   = (state_q == S_WRITE);
        wr_idx_o   = j_q;
        wr_data_o  = {hi_q, lo_q};
        busy_o     = (state_q != S_IDLE);
        done_o     = (state_q == S_DONE);
        sign_ok_o  = sok_q;
        sign_neg_o = sneg_q;
        data_err_o = err_q;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unpack_q <= 1'b0;
            alt_q    <= 1'b0;
            slen_q   <= '0;
            dlen_q   <= '0;
            j_q      <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
            err_q    <= 1'b0;
            sok_q    <= 1'b0;
            sneg_q   <= 1'b0;
        end else if (accept) begin
            unpack_q <= unpack_i;
            alt_q    <= alt_mode_i;
            slen_q   <= src_len_i;
            dlen_q   <= dst_len_i;
            j_q      <= '0;
            err_q    <= 1'b0;
            sok_q    <= 1'b0;
            sneg_q   <= 1'b0;
        end else begin
            if (picking && (state_q == S_PICK_LO)) lo_q <= pick_val;
            if (picking && (state_q == S_PICK_HI)) hi_q <= pick_val;
            if (picking && digit_bad) err_q <= 1'b1;
            if (picking && (map_kind == NIB_SIGN)) begin
                sok_q  <= sg_ok;
                sneg_q <= sg_neg;
                if (!sg_ok) err_q <= 1'b1;
            end
            if ((state_q == S_WRITE) && wr_ack_i && !last_out) j_q <= j_q + 1'b1;
        end
    end

endmodule

// File: rtl/dpk_engine_chk.sv
module dpk_engine_chk #(
    parameter int LEN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             rd_req_o,
    input logic [LEN_W-1:0] rd_idx_o,
    input logic             rd_ack_i,
    input logic             wr_req_o,
    input logic [LEN_W-1:0] wr_idx_o,
    input logic [7:0]       wr_data_o,
    input logic             wr_ack_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             sign_ok_o,
    input logic             sign_neg_o,
    input logic             data_err_o
);
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_idx_o));

    p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_idx_o) && $stable(wr_data_o));

    p_one_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && wr_req_o));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);

    p_done_after_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(wr_req_o && wr_ack_i));

    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rd_req_o && !wr_req_o && !done_o);

    p_bad_sign_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !sign_ok_o |-> data_err_o);

    p_neg_needs_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sign_neg_o |-> sign_ok_o);

    p_flags_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !start_i |=> $stable({sign_ok_o, sign_neg_o, data_err_o}));

endmodule

bind dpk_engine dpk_engine_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rd_req_o  (rd_req_o),
    .rd_idx_o  (rd_idx_o),
    .rd_ack_i  (rd_ack_i),
    .wr_req_o  (wr_req_o),
    .wr_idx_o  (wr_idx_o),
    .wr_data_o (wr_data_o),
    .wr_ack_i  (wr_ack_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .sign_ok_o (sign_ok_o),
    .sign_neg_o(sign_neg_o),
    .data_err_o(data_err_o)
);

// File: tb/dpk_engine_bench.sv
`timescale 1ns/1ps
module dpk_engine_bench;

    localparam int LEN_W = 4;
    localparam int NBYTE = 1 << LEN_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             unpack_i = 1'b0;
    logic             alt_mode_i = 1'b0;
    logic [LEN_W-1:0] src_len_i = '0;
    logic [LEN_W-1:0] dst_len_i = '0;
    logic             rd_req_o;
    logic [LEN_W-1:0] rd_idx_o;
    logic             rd_ack_i = 1'b0;
    logic [7:0]       rd_data_i = '0;
    logic             wr_req_o;
    logic [LEN_W-1:0] wr_idx_o;
    logic [7:0]       wr_data_o;
    logic             wr_ack_i = 1'b0;
    logic             busy_o, done_o, sign_ok_o, sign_neg_o, data_err_o;

    always #2 clk = ~clk;

    dpk_engine #(.LEN_W(LEN_W)) u_dpk_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .unpack_i(unpack_i),
        .alt_mode_i(alt_mode_i), .src_len_i(src_len_i), .dst_len_i(dst_len_i),
        .rd_req_o(rd_req_o), .rd_idx_o(rd_idx_o), .rd_ack_i(rd_ack_i),
        .rd_data_i(rd_data_i), .wr_req_o(wr_req_o), .wr_idx_o(wr_idx_o),
        .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i), .busy_o(busy_o),
        .done_o(done_o), .sign_ok_o(sign_ok_o), .sign_neg_o(sign_neg_o),
        .data_err_o(data_err_o)
    );

    int unsigned vectors = 0;
    int unsigned miscompares = 0;
    int unsigned cyc = 0;
    bit          hung = 1'b0;

    logic [7:0] src_mem [NBYTE];
    logic [7:0] dst_mem [NBYTE];
    logic [7:0] exp_dst [NBYTE];
    logic       exp_ok, exp_neg, exp_err;
    int         exp_reads;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {exists, value} of source digit k
    function automatic logic [4:0] src_digit(input bit up, input int k, input int sl);
        int b;
        logic hi;
        if (!up) begin
            b = k; hi = 1'b0;
        end else if (k == 0) begin
            b = 0; hi = 1'b1;
        end else if (k % 2 == 1) begin
            b = (k + 1) / 2; hi = 1'b0;
        end else begin
            b = k / 2; hi = 1'b1;
        end
        if (b > sl) return 5'd0;
        return {1'b1, hi ? src_mem[b][7:4] : src_mem[b][3:0]};
    endfunction

    task automatic compute_expected(input bit up, input bit alt, input int sl, input int dl);
        logic [3:0] sn, code, lo, hi;
        logic [4:0] d;
        int kmax, lim;
        sn      = up ? src_mem[0][3:0] : src_mem[0][7:4];
        exp_ok  = (sn >= 4'hA);
        exp_neg = exp_ok && (sn == 4'hB || sn == 4'hD);
        exp_err = !exp_ok;
        code    = alt ? (exp_neg ? 4'hD : 4'hC) : (exp_neg ? 4'hB : 4'hA);
        for (int j = 0; j <= dl; j++) begin
            if (!up) begin
                d  = (j == 0) ? {1'b0, code} : src_digit(up, 2*j-1, sl);
                lo = d[3:0];
                d  = src_digit(up, 2*j, sl);
                hi = d[3:0];
            end else begin
                d  = src_digit(up, j, sl);
                lo = d[3:0];
                hi = (j == 0) ? code : (alt ? 4'hF : 4'h3);
            end
            exp_dst[j] = {hi, lo};
        end
        kmax = up ? dl : 2*dl;
        for (int k = 0; k <= kmax; k++) begin
            d = src_digit(up, k, sl);
            if (d[4] && d[3:0] > 4'd9) exp_err = 1'b1;
        end
        lim = up ? ((dl + 1) / 2 + 1) : (2*dl + 1);
        exp_reads = (sl + 1 < lim) ? sl + 1 : lim;
    endtask

    task automatic run_op(input bit up, input bit alt, input int sl, input int dl,
                          input int wmax, input bit restart, input string tag);
        int n, rw, ww, rd_cnt, wr_cnt, first_req, last_wr, done_n;
        bit fin, order_bad, worder_bad;
        compute_expected(up, alt, sl, dl);
        rw = 0; ww = 0; rd_cnt = 0; wr_cnt = 0;
        first_req = -1; last_wr = -100; done_n = -1;
        fin = 1'b0; order_bad = 1'b0; worder_bad = 1'b0;
        @(negedge clk);
        start_i = 1'b1; unpack_i = up; alt_mode_i = alt;
        src_len_i = LEN_W'(sl); dst_len_i = LEN_W'(dl);
        @(negedge clk);
        n = 1;
        start_i = 1'b0;
        // R11: fields change after start; must not matter
        unpack_i = 1'($urandom); alt_mode_i = 1'($urandom);
        src_len_i = LEN_W'($urandom); dst_len_i = LEN_W'($urandom);
        // R12: accepted start clears flags
        check("R12 flags cleared", {sign_ok_o, sign_neg_o, data_err_o}, 3'b000);
        while (!fin) begin
            if (first_req < 0 && rd_req_o) first_req = n;
            if (rd_ack_i) rd_ack_i = 1'b0;
            else if (rd_req_o) begin
                if (rw == 0) begin
                    rd_ack_i  = 1'b1;
                    rd_data_i = src_mem[rd_idx_o];
                    if (int'(rd_idx_o) != rd_cnt) order_bad = 1'b1;
                    rd_cnt++;
                    rw = $urandom % (wmax + 1);
                end else rw--;
            end
            if (wr_ack_i) wr_ack_i = 1'b0;
            else if (wr_req_o) begin
                if (ww == 0) begin
                    wr_ack_i = 1'b1;
                    dst_mem[wr_idx_o] = wr_data_o;
                    if (int'(wr_idx_o) != wr_cnt) worder_bad = 1'b1;
                    wr_cnt++;
                    last_wr = n;
                    ww = $urandom % (wmax + 1);
                end else ww--;
            end
            if (done_o) begin
                done_n = n;
                fin = 1'b1;
            end
            if (restart && n == 3) begin
                start_i = 1'b1; unpack_i = ~up; alt_mode_i = ~alt;
                src_len_i = '0; dst_len_i = '0;
            end
            if (restart && n == 4) start_i = 1'b0;
            if (!fin && (n > 800 || cyc > 190000)) begin
                fin = 1'b1;
                hung = 1'b1;
            end
            if (!fin) begin
                @(negedge clk);
                n++;
            end
        end
        if (hung) begin
            check("watchdog expired", 32'd1, 32'd0);
            return;
        end
        for (int j = 0; j <= dl; j++)
            check({tag, " dst byte"}, {24'd0, dst_mem[j]}, {24'd0, exp_dst[j]});
        check("R3 sign_ok", {31'd0, sign_ok_o}, {31'd0, exp_ok});
        check("R3 sign_neg", {31'd0, sign_neg_o}, {31'd0, exp_neg});
        check("R6 data_err", {31'd0, data_err_o}, {31'd0, exp_err});
        check("R8 read count", rd_cnt, exp_reads);
        check("R8 read order", {31'd0, order_bad}, 32'd0);
        check("R8 write count", wr_cnt, dl + 1);
        check("R8 write order", {31'd0, worder_bad}, 32'd0);
        check("R10 first read edge", first_req, 2);
        check("R10 done edge", done_n, last_wr + 1);
        @(negedge clk);
        check("R10 done pulse ends", {30'd0, done_o, busy_o}, 32'd0);
        check("R12 flags held", {29'd0, sign_ok_o, sign_neg_o, data_err_o},
              {29'd0, exp_ok, exp_neg, exp_err});
    endtask

    task automatic fill_random(input bit up, input int bad_pct);
        for (int b = 0; b < NBYTE; b++) begin
            logic [3:0] h, l;
            h = ($urandom % 100 < bad_pct) ? 4'(10 + $urandom % 6) : 4'($urandom % 10);
            l = ($urandom % 100 < bad_pct) ? 4'(10 + $urandom % 6) : 4'($urandom % 10);
            if (!up) h = 4'($urandom);   // zones are arbitrary
            src_mem[b] = {h, l};
        end
        if (up) src_mem[0][3:0] = ($urandom % 8 == 0) ? 4'($urandom % 10) : 4'(10 + $urandom % 6);
        else    src_mem[0][7:4] = ($urandom % 8 == 0) ? 4'($urandom % 10) : 4'(10 + $urandom % 6);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int b = 0; b < NBYTE; b++) begin src_mem[b] = '0; dst_mem[b] = '0; end
        repeat (3) @(negedge clk);
        check("R12 reset flags", {29'd0, sign_ok_o, sign_neg_o, data_err_o}, 32'd0);
        check("R10 reset idle", {28'd0, busy_o, done_o, rd_req_o, wr_req_o}, 32'd0);
        rst_n = 1'b1;

        // R1: +123 zoned -> packed, standard signs
        src_mem[0] = 8'hC3; src_mem[1] = 8'hF2; src_mem[2] = 8'hF1;
        run_op(1'b0, 1'b0, 2, 1, 0, 1'b0, "R1");
        check("R1 packed lsb", {24'd0, dst_mem[0]}, 32'h3A);
        check("R1 packed msb", {24'd0, dst_mem[1]}, 32'h12);

        // R2: packed 123+ -> zoned, standard zones
        src_mem[0] = 8'h3C; src_mem[1] = 8'h12;
        run_op(1'b1, 1'b0, 1, 2, 1, 1'b0, "R2");
        check("R2 zoned byte0", {24'd0, dst_mem[0]}, 32'hA3);
        check("R2 zoned byte2", {24'd0, dst_mem[2]}, 32'h31);
        run_op(1'b1, 1'b1, 1, 2, 0, 1'b0, "R2");
        check("R2 alt zone", {24'd0, dst_mem[1]}, 32'hF2);

        // R3/R4: every sign nibble in both conventions
        for (int s = 0; s < 16; s++) begin
            for (int a = 0; a < 2; a++) begin
                src_mem[0] = {4'(s), 4'h7};
                run_op(1'b0, 1'(a), 0, 0, 0, 1'b0, "R4");
            end
        end

        // R5: padding and truncation
        fill_random(1'b0, 0);
        run_op(1'b0, 1'b0, 1, 5, 2, 1'b0, "R5");
        check("R5 pad zero", {24'd0, dst_mem[5]}, 32'h00);
        fill_random(1'b1, 0);
        run_op(1'b1, 1'b1, 0, 6, 1, 1'b0, "R5");
        fill_random(1'b0, 0);
        run_op(1'b0, 1'b1, 9, 1, 0, 1'b0, "R5");
        fill_random(1'b1, 0);
        run_op(1'b1, 1'b0, 7, 2, 2, 1'b0, "R5");
        fill_random(1'b0, 0);
        run_op(1'b0, 1'b0, 15, 15, 1, 1'b0, "R5");
        fill_random(1'b1, 0);
        run_op(1'b1, 1'b1, 15, 15, 1, 1'b0, "R5");

        // R6: bad digit copied, error raised
        src_mem[0] = 8'hD4; src_mem[1] = 8'hFE; src_mem[2] = 8'hF9;
        run_op(1'b0, 1'b1, 2, 1, 0, 1'b0, "R6");
        check("R6 bad digit copied", {24'd0, dst_mem[1]}, 32'h9E);
        check("R6 error", {31'd0, data_err_o}, 32'd1);

        // R7: zones of non-sign bytes ignored
        src_mem[0] = 8'hB5; src_mem[1] = 8'h06; src_mem[2] = 8'hA7;
        run_op(1'b0, 1'b0, 2, 1, 0, 1'b0, "R7");
        check("R7 zones ignored", {16'd0, dst_mem[1], dst_mem[0]}, 32'h765B);
        check("R7 no error", {31'd0, data_err_o}, 32'd0);

        // R11: start while busy ignored
        fill_random(1'b0, 0);
        run_op(1'b0, 1'b0, 5, 3, 2, 1'b1, "R11");

        // Random mix
        for (int t = 0; t < 60 && !hung; t++) begin
            bit up;
            up = 1'($urandom);
            fill_random(up, 5);
            run_op(up, 1'($urandom), int'($urandom % 16), int'($urandom % 16),
                   int'($urandom % 4), ($urandom % 6 == 0), up ? "R2" : "R1");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule